// File: doc/BRIEF.md
# Programmable Binary Divider Timer

This block is a 24-stage ripple-style binary divider rebuilt as synchronous logic. A slow timing input is sampled by the system clock, and each falling transition advances the chain by one. A 4-bit select code picks one stage of the upper sixteen to drive a single decoded output. With the pulse generator off, that output is a square wave at the chosen division ratio. With the generator on, each rising transition of the chosen stage fires a pulse whose width is counted in system clocks. The full count is brought out so it can be observed.

Several controls shape the sequence. Preset forces the output high and clears the chain. The first falling edge after preset is released only drops the output, and counting starts on the second edge. Clear forces the output low and clears the chain. A bypass skips the low eight stages, and two hold inputs freeze the count. A test configuration, entered by raising bypass, preset and clear together, splits the chain into three independent 8-stage sections that all count at once.

A control state machine tracks the sequence. Its states are CS_RUN (counting), CS_CLEAR (clear seen), CS_PRESET (preset seen), CS_ARMED (preset released, waiting for the first edge) and CS_TEST (split-chain test). The transitions are as follows:
- The test combination moves any state to CS_TEST.
- Clear moves any state to CS_CLEAR; preset moves any state to CS_PRESET.
- With no control active, CS_CLEAR and CS_TEST go back to CS_RUN, and CS_RUN stays in CS_RUN.
- CS_PRESET and CS_ARMED go to CS_RUN on a falling edge, or else to CS_ARMED.

The pulse generator has two states. PG_IDLE moves to PG_FIRE on a rising edge of the selected stage. PG_FIRE returns to PG_IDLE when its width counter runs out.

Top module: `prog_divider_timer`

## Requirements
- R1: The timing input passes through a two-flop synchronizer. Each falling edge seen on it advances `count_o` by one, where bit 0 is stage 1, provided bypass, preset, clear and both holds are low.
- R2: While `set_i` is high and `clr_i` is low, `dout_o` is 1 in the same cycle, and `count_o` reads 0 from the next cycle on.
- R3: After `set_i` falls, `dout_o` stays 1 until the first falling edge of the timing input. That edge drives `dout_o` to 0 and leaves the count at 0. The second edge makes the count 1.
- R4: While `clr_i` is high outside test mode, `dout_o` is 0 in the same cycle and `count_o` reads 0 from the next cycle on. This holds even when `set_i` is also high.
- R5: With the pulse generator off, `dout_o` equals `count_o[8 + sel_i]`. Code 0 therefore selects stage 9 and code 15 selects stage 24.
- R6: With `bypass_i` high, `count_o[7:0]` holds, and each edge advances `count_o[23:8]` as a 16-stage counter. Code 0 then selects that counter's first stage.
- R7: While `hold_i` is high, edges do not change `count_o`. After it falls, the first edge counts.
- R8: `osc_hold_i` stops counting in exactly the same way as `hold_i`.
- R9: With `bypass_i`, `set_i` and `clr_i` all high, the count is not cleared. Each edge adds one to each of `count_o[7:0]`, `count_o[15:8]` and `count_o[23:16]`, with no carry between them, and `dout_o` shows the selected stage.
- R10: With `pulse_en_i` high, a rising edge of the selected stage drives `dout_o` high for exactly `pulse_len_i` system clocks, or one clock when that value is 0. A rise that comes while a pulse is running does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of all state |
| tin_i | input | 1 | Asynchronous timing input; falling edges count |
| set_i | input | 1 | Preset: output high, chain cleared |
| clr_i | input | 1 | Clear: output low, chain cleared |
| bypass_i | input | 1 | Skip the low eight stages |
| hold_i | input | 1 | Freeze the count |
| osc_hold_i | input | 1 | Second freeze input, same effect |
| sel_i | input | 4 | Stage select code |
| pulse_en_i | input | 1 | Enable the pulse generator on the output |
| pulse_len_i | input | 8 | Pulse width in system clocks |
| dout_o | output | 1 | Decoded output |
| count_o | output | 24 | Full chain value, bit 0 = stage 1 |

## Verification
Preset and clear can be active in the same cycle. The bench drives both high with bypass low and expects the output low and the count zero after several timing edges, because clear wins. It then raises bypass together with both of them so that the same two inputs select the split test chain instead. After three edges it expects each section to hold 3 and the output to follow the selected bit. A hold can also coincide with a timing edge. Edges are applied while each hold input is high, and the bench checks that the count is unchanged before the next edge after release adds exactly one.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    typedef enum logic [2:0] {
        CS_RUN,
        CS_CLEAR,
        CS_PRESET,
        CS_ARMED,
        CS_TEST
    } ctl_state_t;

    typedef enum logic {
        PG_IDLE,
        PG_FIRE
    } pulse_state_t;
endpackage

// File: rtl/tdt_edge_detect.sv
module tdt_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/tdt_stage_chain.sv
module tdt_stage_chain #(
    parameter int W   = 24,
    parameter int SEC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         adv_i,
    input  logic         bypass_i,
    input  logic         split_i,
    output logic [W-1:0] count_o
);
    localparam int NSEC = W / SEC;
    localparam logic [W-1:0]     FULL_ONE = 1;
    localparam logic [W-SEC-1:0] UP_ONE   = 1;
    localparam logic [SEC-1:0]   SEC_ONE  = 1;

    logic [W-1:0] count_q;
    logic [W-1:0] nxt_full;
    logic [W-1:0] nxt_byp;
    logic [W-1:0] nxt_split;
    logic [W-1:0] nxt_sel;

    assign nxt_full = count_q + FULL_ONE;
    assign nxt_byp  = {count_q[W-1:SEC] + UP_ONE, count_q[SEC-1:0]};

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        assign nxt_split[s*SEC +: SEC] = count_q[s*SEC +: SEC] + SEC_ONE;
    end

    always_comb begin
        if (split_i)       nxt_sel = nxt_split;
        else if (bypass_i) nxt_sel = nxt_byp;
        else               nxt_sel = nxt_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else if (adv_i)   count_q <= nxt_sel;
    end

    assign count_o = count_q;
endmodule

// File: rtl/tdt_pulse_gen.sv
module tdt_pulse_gen
    import tdt_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             level_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             pulse_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = 1;

    pulse_state_t     state_q, state_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic             prev_q;
    logic             rise;

    assign rise = level_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            left_q  <= '0;
            prev_q  <= 1'b0;
        end else if (clear_i) begin
            state_q <= PG_IDLE;
            left_q  <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            prev_q  <= level_i;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            PG_IDLE: begin
                if (enable_i && rise) begin
                    state_d = PG_FIRE;
                    left_d  = (len_i == '0) ? LEN_ONE : len_i;
                end
            end
            PG_FIRE: begin
                left_d = left_q - LEN_ONE;
                if (left_q == LEN_ONE) state_d = PG_IDLE;
            end
            default: state_d = PG_IDLE;
        endcase
    end

    assign pulse_o = (state_q == PG_FIRE);
endmodule

// File: rtl/prog_divider_timer.sv
module prog_divider_timer
    import tdt_pkg::*;
#(
    parameter int STAGES  = 24,
    parameter int SECTION = 8,
    parameter int SEL_W   = 4,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tin_i,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              bypass_i,
    input  logic              hold_i,
    input  logic              osc_hold_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pulse_en_i,
    input  logic [LEN_W-1:0]  pulse_len_i,
    output logic              dout_o,
    output logic [STAGES-1:0] count_o
);
    localparam int NSEL = STAGES - SECTION;

    ctl_state_t        state_q, state_d;
    logic              fall;
    logic              test_mode, clr_eff, set_eff, chain_clear;
    logic              cnt_phase, advance;
    logic [NSEL-1:0]   upper;
    logic              sel_bit, pulse, stage_out;

    tdt_edge_detect #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tin_i),
        .fall_o   (fall)
    );

    assign test_mode   = bypass_i & set_i & clr_i;
    assign clr_eff     = clr_i & ~test_mode;
    assign set_eff     = set_i & ~clr_i;
    assign chain_clear = clr_eff | set_eff;
    assign cnt_phase   = (state_q == CS_RUN) || (state_q == CS_CLEAR) || (state_q == CS_TEST);
    assign advance     = fall & ~hold_i & ~osc_hold_i & cnt_phase & ~chain_clear;

    tdt_stage_chain #(.W(STAGES), .SEC(SECTION)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (chain_clear),
        .adv_i    (advance),
        .bypass_i (bypass_i),
        .split_i  (test_mode),
        .count_o  (count_o)
    );

    assign upper   = count_o[STAGES-1:SECTION];
    assign sel_bit = upper[sel_i];

    tdt_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (chain_clear),
        .enable_i (pulse_en_i),
        .level_i  (sel_bit),
        .len_i    (pulse_len_i),
        .pulse_o  (pulse)
    );

    assign stage_out = pulse_en_i ? pulse : sel_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        if (test_mode)    state_d = CS_TEST;
        else if (clr_eff) state_d = CS_CLEAR;
        else if (set_eff) state_d = CS_PRESET;
        else begin
            unique case (state_q)
                CS_RUN, CS_CLEAR, CS_TEST: state_d = CS_RUN;
                CS_PRESET, CS_ARMED:       state_d = fall ? CS_RUN : CS_ARMED;
                default:                   state_d = CS_RUN;
            endcase
        end
    end

    // Output logic
    always_comb begin
        if (test_mode)    dout_o = stage_out;
        else if (clr_eff) dout_o = 1'b0;
        else if (set_eff) dout_o = 1'b1;
        else begin
            unique case (state_q)
                CS_RUN, CS_CLEAR, CS_TEST: dout_o = stage_out;
                CS_PRESET, CS_ARMED:       dout_o = 1'b1;
                default:                   dout_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         set_i,
    input logic         clr_i,
    input logic         bypass_i,
    input logic         hold_i,
    input logic         osc_hold_i,
    input logic         dout_o,
    input logic [W-1:0] count_o
);
    AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |-> dout_o); // R2

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(bypass_i && set_i)) |-> !dout_o); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i && !(bypass_i && set_i)) |-> (count_o == '0)); // R4

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past((hold_i || osc_hold_i) && !set_i && !clr_i) |-> $stable(count_o)); // R7

    AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass_i && !set_i && !clr_i) |-> $stable(count_o[7:0])); // R6

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bypass_i && !set_i && !clr_i) |->
            (count_o == $past(count_o) || count_o == W'($past(count_o) + 1'b1))); // R1
endmodule

bind prog_divider_timer tdt_checker #(.W(STAGES)) i_tdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .bypass_i   (bypass_i),
    .hold_i     (hold_i),
    .osc_hold_i (osc_hold_i),
    .dout_o     (dout_o),
    .count_o    (count_o)
);

// File: tb/test_prog_divider_timer.sv
module test_prog_divider_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tin = 1'b0, set = 1'b0, clr = 1'b0, bp = 1'b0;
    logic        hold = 1'b0, ohold = 1'b0, pen = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic [7:0]  plen = 8'd1;
    logic        dout;
    logic [23:0] count;
    int          n_chk = 0, n_err = 0, hi_cnt = 0;
    bit          done = 1'b0;

    typedef struct packed {
        logic        bp;
        logic [3:0]  sel;
        logic [15:0] edges;
        logic [23:0] cnt;
        logic        dout;
    } vec_t;

    // R5 rows use bypass 0, R6 rows use bypass 1
    localparam vec_t VECS [8] = '{
        '{1'b0, 4'd0, 16'd256, 24'd256,    1'b1},
        '{1'b0, 4'd0, 16'd511, 24'd511,    1'b1},
        '{1'b0, 4'd0, 16'd512, 24'd512,    1'b0},
        '{1'b0, 4'd1, 16'd512, 24'd512,    1'b1},
        '{1'b1, 4'd0, 16'd1,   24'h000100, 1'b1},
        '{1'b1, 4'd0, 16'd2,   24'h000200, 1'b0},
        '{1'b1, 4'd2, 16'd4,   24'h000400, 1'b1},
        '{1'b1, 4'd3, 16'd7,   24'h000700, 1'b0}
    };

    prog_divider_timer i_prog_divider_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tin_i       (tin),
        .set_i       (set),
        .clr_i       (clr),
        .bypass_i    (bp),
        .hold_i      (hold),
        .osc_hold_i  (ohold),
        .sel_i       (sel),
        .pulse_en_i  (pen),
        .pulse_len_i (plen),
        .dout_o      (dout),
        .count_o     (count)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (dout === 1'b1) hi_cnt++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_edge();
        tin = 1'b1; wait_cyc(4);
        tin = 1'b0; wait_cyc(4);
    endtask

    task automatic do_clear();
        clr = 1'b1; wait_cyc(2);
        clr = 1'b0; wait_cyc(2);
    endtask

    task automatic zero_hi();
        @(posedge clk); hi_cnt = 0; @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 reset count", count, 0);
        check("R5 reset dout", dout, 0);

        // table walk: R1 R5 R6
        foreach (VECS[i]) begin
            bp = VECS[i].bp; sel = VECS[i].sel;
            do_clear();
            for (int e = 0; e < int'(VECS[i].edges); e++) fall_edge();
            check(VECS[i].bp ? "R6 count" : "R1 count", count, VECS[i].cnt);
            check(VECS[i].bp ? "R6 dout" : "R5 dout", dout, VECS[i].dout);
        end
        bp = 1'b0; sel = 4'd0;

        // R2 preset, R3 sequence after release
        fall_edge(); fall_edge();
        set = 1'b1; wait_cyc(1);
        check("R2 dout high", dout, 1);
        wait_cyc(2);
        check("R2 count cleared", count, 0);
        fall_edge();
        check("R2 no count under preset", count, 0);
        set = 1'b0; wait_cyc(2);
        check("R3 armed dout", dout, 1);
        fall_edge();
        check("R3 first edge dout", dout, 0);
        check("R3 first edge count", count, 0);
        fall_edge();
        check("R3 second edge count", count, 1);

        // R4 clear with and without preset
        fall_edge(); fall_edge();
        clr = 1'b1; wait_cyc(1);
        check("R4 dout low", dout, 0);
        wait_cyc(2);
        check("R4 count cleared", count, 0);
        set = 1'b1; wait_cyc(1);
        fall_edge(); fall_edge();
        check("R4 priority dout", dout, 0);
        check("R4 priority count", count, 0);
        set = 1'b0; clr = 1'b0; wait_cyc(2);

        // R7 hold
        do_clear();
        fall_edge(); fall_edge(); fall_edge();
        hold = 1'b1; wait_cyc(1);
        fall_edge(); fall_edge();
        check("R7 held count", count, 3);
        hold = 1'b0; wait_cyc(1);
        fall_edge();
        check("R7 resume count", count, 4);

        // R8 oscillator hold
        ohold = 1'b1; wait_cyc(1);
        fall_edge(); fall_edge();
        check("R8 held count", count, 4);
        ohold = 1'b0; wait_cyc(1);
        fall_edge();
        check("R8 resume count", count, 5);

        // R9 split test chain
        bp = 1'b1; do_clear();
        clr = 1'b1; set = 1'b1; wait_cyc(2);
        check("R9 entry no clear", count, 0);
        fall_edge(); fall_edge(); fall_edge();
        check("R9 sections", count, 24'h030303);
        check("R9 dout", dout, 1);
        for (int e = 0; e < 254; e++) fall_edge();
        check("R9 section wrap", count, 24'h010101);
        set = 1'b0; clr = 1'b0; bp = 1'b0; wait_cyc(2);

        // R10 pulse generator
        pen = 1'b1; bp = 1'b1; sel = 4'd0; plen = 8'd5;
        do_clear(); zero_hi();
        fall_edge(); wait_cyc(20);
        check("R10 width 5", hi_cnt, 5);
        plen = 8'd0;
        do_clear(); zero_hi();
        fall_edge(); wait_cyc(10);
        check("R10 width zero", hi_cnt, 1);
        plen = 8'd200;
        do_clear(); zero_hi();
        fall_edge(); fall_edge(); fall_edge(); wait_cyc(250);
        check("R10 no retrigger", hi_cnt, 200);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule